// File: doc/BRIEF.md
# Prefix-Extended AND-Immediate Execution Unit

This unit executes one 16-bit instruction: a bitwise AND of a destination register with an immediate operand. The result goes back into that same register. The unit owns a 16-entry, 32-bit register file. It updates the negative, zero and overflow flags and leaves the carry flag alone.

The immediate field in the instruction word is only 6 bits wide. Up to two extension words placed directly before the instruction can widen it. Each extension word carries 13 immediate bits. With one extension word the operand is 19 bits wide and is sign-extended from its top bit. With two extension words the operand is a full 32-bit value. When an instruction sits in a branch delay slot, any pending extension words are disregarded and the 6-bit form is used.

A side load port lets the surrounding datapath place values into the register file, standing in for the other writers of that file. Each accepted AND drives the write-port outputs and the flags for one cycle, one clock edge after the word is presented.

Top module: `ext_and_unit`

## Requirements
- R1: Synchronous active-low reset clears every register, all four flags, the extension count and the write-enable output.
- R2: A valid word with bits 15:10 equal to 6'b011100 is an AND. Bits 9:4 are a signed 6-bit immediate and bits 3:0 are the destination index. With no extension pending, the operand is that immediate sign-extended to 32 bits.
- R3: The AND result is written to the destination register. It also appears on wr_data with wr_idx and wr_en=1 in the cycle after the clock edge that accepts the word.
- R4: A valid word with bits 15:13 equal to 3'b110 is an extension word carrying 13 bits in 12:0. With one pending extension E, the operand is {E, imm6} (19 bits), sign-extended from bit 18.
- R5: With two pending extensions E1 then E2, the operand is {E1, E2, imm6} (32 bits).
- R6: A third consecutive extension word discards the oldest one, so only the two most recent are used.
- R7: Any valid non-extension word clears the pending extensions once it executes.
- R8: An AND flagged as in a delay slot ignores pending extensions and uses the sign-extended 6-bit immediate.
- R9: On each AND, N takes result bit 31, Z is set exactly when the result is zero, V is cleared and C keeps its value.
- R10: A word presented without instr_valid changes no state: no write occurs and pending extensions are kept.
- R11: The load port writes ld_data into register ld_idx at the clock edge. If an AND targets the same cycle, the AND write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Qualifies instr_word this cycle |
| instr_word | input | 16 | Instruction or extension word |
| in_delay_slot | input | 1 | Word executes in a branch delay slot |
| ld_en | input | 1 | Side load enable |
| ld_idx | input | 4 | Side load register index |
| ld_data | input | 32 | Side load data |
| wr_en | output | 1 | AND result committed last edge |
| wr_idx | output | 4 | Destination index of committed result |
| wr_data | output | 32 | Committed result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench targets the three places where the operand is assembled, each with a known mask. A unit that sign-extends from the wrong bit in the one-extension case shows up when extension bit 12 is set, because the upper 13 result bits would come out zero instead of ones. A unit that consults pending extensions in a delay slot, forgets to clear them after an AND, or keeps the oldest of three extension words produces a wrong mask on the following AND. Idle cycles carrying an extension opcode without the valid strobe must neither write anything nor disturb a pending extension.

// File: rtl/ext_and_pkg.sv
// Package: shared widths and decode helpers for the AND-immediate unit.
// Assumes the fixed 16-bit instruction layout described in the brief.
package ext_and_pkg;
    localparam int WORD_W  = 16;
    localparam int DATA_W  = 32;
    localparam int PFX_W   = 13;
    localparam int SHORT_W = 6;
    localparam int NREGS   = 16;
    localparam int IDX_W   = $clog2(NREGS);
    localparam int MID_W   = PFX_W + SHORT_W;          // 19-bit form
    localparam int CNT_W   = 2;

    localparam logic [5:0] AND_OP = 6'b011100;
    localparam logic [2:0] PFX_OP = 3'b110;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [PFX_W-1:0]  pfx_t;

    // Recognise the AND-immediate opcode
    function automatic logic is_and(input logic [WORD_W-1:0] w);
        return w[15:10] == AND_OP;
    endfunction

    // Recognise an extension word
    function automatic logic is_pfx(input logic [WORD_W-1:0] w);
        return w[15:13] == PFX_OP;
    endfunction
endpackage

// File: rtl/pfx_tracker.sv
// Tracks up to two pending extension words. slot_a holds the older word and
// slot_b the newer one; a third push shifts b into a. A clear empties it.
// Assumes push and clear are never requested together.
module pfx_tracker
    import ext_and_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             clear,
    input  pfx_t             pfx_in,
    output logic [CNT_W-1:0] count,
    output pfx_t             slot_a,
    output pfx_t             slot_b
);
    // Update count and holding slots on push or clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            slot_a <= '0;
            slot_b <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push) begin
            case (count)
                2'd0: begin
                    slot_a <= pfx_in;
                    count  <= 2'd1;
                end
                2'd1: begin
                    slot_b <= pfx_in;
                    count  <= 2'd2;
                end
                default: begin
                    slot_a <= slot_b;
                    slot_b <= pfx_in;
                    count  <= 2'd2;
                end
            endcase
        end
    end
endmodule

// File: rtl/imm_builder.sv
// Builds the 32-bit operand from the short immediate and pending extensions.
// Purely combinational; a set bypass forces the short form.
module imm_builder
    import ext_and_pkg::*;
(
    input  logic [CNT_W-1:0]   count,
    input  logic               bypass,
    input  pfx_t               slot_a,
    input  pfx_t               slot_b,
    input  logic [SHORT_W-1:0] imm_short,
    output data_t              operand
);
    logic [MID_W-1:0] mid;

    // Select the operand form by extension count
    always_comb begin
        mid = {slot_a, imm_short};
        if (bypass || count == 2'd0)
            operand = {{(DATA_W-SHORT_W){imm_short[SHORT_W-1]}}, imm_short};
        else if (count == 2'd1)
            operand = {{(DATA_W-MID_W){mid[MID_W-1]}}, mid};
        else
            operand = {slot_a, slot_b, imm_short};
    end
endmodule

// File: rtl/and_regfile.sv
// Register file with two write ports (execute has priority over load) and
// one combinational read port. All entries clear on reset.
module and_regfile
    import ext_and_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_we,
    input  logic [IDX_W-1:0] ex_idx,
    input  data_t            ex_data,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  data_t            ld_data,
    input  logic [IDX_W-1:0] rd_idx,
    output data_t            rd_data
);
    data_t regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        // Write one entry, execute port first
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (ex_we && ex_idx == IDX_W'(i))
                regs[i] <= ex_data;
            else if (ld_we && ld_idx == IDX_W'(i))
                regs[i] <= ld_data;
        end
    end

    // Read the selected entry
    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/ext_and_unit.sv
// Top: decodes the word stream, assembles the operand, executes the AND in
// one cycle and registers the write-port view and the flags.
// Assumes one word per cycle at most, qualified by instr_valid.
module ext_and_unit
    import ext_and_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic [15:0] instr_word,
    input  logic        in_delay_slot,
    input  logic        ld_en,
    input  logic [3:0]  ld_idx,
    input  logic [31:0] ld_data,
    output logic        wr_en,
    output logic [3:0]  wr_idx,
    output logic [31:0] wr_data,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c
);
    logic             do_and, do_pfx, do_clear;
    logic [CNT_W-1:0] pcount;
    pfx_t             pa, pb;
    data_t            operand, src, result;
    logic [IDX_W-1:0] dst;

    // Classify the presented word
    always_comb begin
        do_and   = instr_valid && is_and(instr_word);
        do_pfx   = instr_valid && is_pfx(instr_word);
        do_clear = instr_valid && !is_pfx(instr_word);
        dst      = instr_word[IDX_W-1:0];
    end

    pfx_tracker u_pfx (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (do_pfx),
        .clear  (do_clear),
        .pfx_in (instr_word[PFX_W-1:0]),
        .count  (pcount),
        .slot_a (pa),
        .slot_b (pb)
    );

    imm_builder u_imm (
        .count     (pcount),
        .bypass    (in_delay_slot),
        .slot_a    (pa),
        .slot_b    (pb),
        .imm_short (instr_word[9:4]),
        .operand   (operand)
    );

    and_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ex_we   (do_and),
        .ex_idx  (dst),
        .ex_data (result),
        .ld_we   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .rd_idx  (dst),
        .rd_data (src)
    );

    // The operation itself
    assign result = src & operand;

    // Register write-port view and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_v  <= 1'b0;
            flag_c  <= 1'b0;
        end else begin
            wr_en <= do_and;
            if (do_and) begin
                wr_idx  <= dst;
                wr_data <= result;
                flag_n  <= result[DATA_W-1];
                flag_z  <= (result == '0);
                flag_v  <= 1'b0;
            end
        end
    end
endmodule

// Checker: temporal properties of the unit's ports.
module ext_and_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [15:0] instr_word,
    input logic        in_delay_slot,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c
);
    // R3
    wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(instr_valid && instr_word[15:10] == 6'b011100));
    // R3
    wr_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx == $past(instr_word[3:0]));
    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (flag_z == (wr_data == 32'd0)) && (flag_n == wr_data[31]) && !flag_v);
    // R9
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(flag_c));
    // R10
    idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !wr_en);
    // R8
    slot_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_word[15:10] == 6'b011100 && in_delay_slot)
        |=> (wr_data & ~{{26{$past(instr_word[9])}}, $past(instr_word[9:4])}) == 32'd0);
endmodule

bind ext_and_unit ext_and_unit_chk u_chk (.*);

// File: tb/ext_and_unit_test.sv
module ext_and_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        in_delay_slot = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        wr_en, flag_n, flag_z, flag_v, flag_c;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ext_and_unit uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] and_w(input logic [5:0] imm, input logic [3:0] rd);
        return {6'b011100, imm, rd};
    endfunction
    function automatic logic [15:0] pfx_w(input logic [12:0] v);
        return {3'b110, v};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Present one valid word; outputs are sampled on the following negedge
    task automatic issue(input logic [15:0] w, input bit ds);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w; in_delay_slot = ds;
        @(negedge clk);
        instr_valid = 1'b0; in_delay_slot = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [3:0] idx, input logic [31:0] exp);
        check(wr_en === 1'b1, req, {31'd0, wr_en}, 32'd1);
        check(wr_idx === idx, req, {28'd0, wr_idx}, {28'd0, idx});
        check(wr_data === exp, req, wr_data, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs clear
        check(wr_en === 1'b0 && flag_n === 1'b0 && flag_z === 1'b0 && flag_v === 1'b0 && flag_c === 1'b0,
              "R1", {27'd0, wr_en, flag_n, flag_z, flag_v, flag_c}, 32'd0);
        rst_n = 1'b1;
        // R1: registers cleared, AND of r5 with all ones gives zero
        issue(and_w(6'h3f, 4'd5), 1'b0);
        expect_write("R1", 4'd5, 32'h0);
        check(flag_z === 1'b1, "R9", {31'd0, flag_z}, 32'd1);
    endtask

    task automatic t_short;
        load(4'd0, 32'hffffffff);
        issue(and_w(6'h3e, 4'd0), 1'b0);
        expect_write("R2", 4'd0, 32'hfffffffe);
        check(flag_n === 1'b1 && flag_z === 1'b0 && flag_v === 1'b0, "R9",
              {29'd0, flag_n, flag_z, flag_v}, 32'h4);
        check(flag_c === 1'b0, "R9", {31'd0, flag_c}, 32'd0);
        // R3: written back, AND again with positive imm
        issue(and_w(6'h15, 4'd0), 1'b0);
        expect_write("R3", 4'd0, 32'h14);
        check(flag_n === 1'b0, "R9", {31'd0, flag_n}, 32'd0);
    endtask

    task automatic t_one_ext;
        load(4'd1, 32'hffffffff);
        issue(pfx_w(13'h7ff), 1'b0);
        check(wr_en === 1'b0, "R4", {31'd0, wr_en}, 32'd0);
        issue(and_w(6'h3f, 4'd1), 1'b0);
        expect_write("R4", 4'd1, 32'h0001ffff);
        // R4: sign extension from bit 18
        load(4'd2, 32'hffffffff);
        issue(pfx_w(13'h1000), 1'b0);
        issue(and_w(6'h01, 4'd2), 1'b0);
        expect_write("R4", 4'd2, 32'hfffc0001);
    endtask

    task automatic t_two_ext;
        logic [31:0] e;
        e = {13'h1234, 13'h0abc, 6'h15};
        load(4'd3, 32'hffffffff);
        issue(pfx_w(13'h1234), 1'b0);
        issue(pfx_w(13'h0abc), 1'b0);
        issue(and_w(6'h15, 4'd3), 1'b0);
        expect_write("R5", 4'd3, e);
        // R7: count cleared, next AND uses short form
        load(4'd3, 32'hffffffff);
        issue(and_w(6'h20, 4'd3), 1'b0);
        expect_write("R7", 4'd3, 32'hffffffe0);
    endtask

    task automatic t_three_ext;
        load(4'd4, 32'hffffffff);
        issue(pfx_w(13'h1fff), 1'b0);
        issue(pfx_w(13'h0001), 1'b0);
        issue(pfx_w(13'h0002), 1'b0);
        issue(and_w(6'h03, 4'd4), 1'b0);
        expect_write("R6", 4'd4, {13'h0001, 13'h0002, 6'h03});
    endtask

    task automatic t_delay_slot;
        load(4'd6, 32'hffffffff);
        issue(pfx_w(13'h0000), 1'b0);
        issue(and_w(6'h3e, 4'd6), 1'b1);
        expect_write("R8", 4'd6, 32'hfffffffe);
        // R7: extension consumed by the delay-slot AND
        load(4'd6, 32'hffffffff);
        issue(and_w(6'h3e, 4'd6), 1'b0);
        expect_write("R7", 4'd6, 32'hfffffffe);
    endtask

    task automatic t_invalid;
        load(4'd7, 32'hffffffff);
        issue(pfx_w(13'h0001), 1'b0);
        @(negedge clk);
        instr_word = pfx_w(13'h1fff);   // not valid
        @(negedge clk);
        check(wr_en === 1'b0, "R10", {31'd0, wr_en}, 32'd0);
        instr_word = and_w(6'h00, 4'd7); // not valid
        @(negedge clk);
        check(wr_en === 1'b0, "R10", {31'd0, wr_en}, 32'd0);
        issue(and_w(6'h05, 4'd7), 1'b0);
        expect_write("R10", 4'd7, 32'h00000045);
    endtask

    task automatic t_load_priority;
        load(4'd8, 32'hffffffff);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = and_w(6'h3c, 4'd8);
        ld_en = 1'b1; ld_idx = 4'd8; ld_data = 32'h0;
        @(negedge clk);
        instr_valid = 1'b0; ld_en = 1'b0;
        expect_write("R11", 4'd8, 32'hfffffffc);
        issue(and_w(6'h3f, 4'd8), 1'b0);
        expect_write("R11", 4'd8, 32'hfffffffc);
    endtask

    initial begin
        t_reset();
        t_short();
        t_one_ext();
        t_two_ext();
        t_three_ext();
        t_delay_slot();
        t_invalid();
        t_load_priority();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule